// File: doc/BRIEF.md
# Software Write-Lock Sequence Guard

This block sits between the bus-write latch of a parallel non-volatile memory and its page-load engine. It observes every latched write (a one-cycle strobe with a 17-bit address and an 8-bit data byte). It keeps a persistent lock flag that is controlled by software through two fixed command sequences written to magic addresses. A three-write arming prefix turns the lock on and opens a load window, so the page that follows is still written. A six-write release sequence turns the lock off.

Command bytes are absorbed: the write-permit output is never raised for them. While unlocked, ordinary writes pass straight through. While locked, ordinary writes are refused unless they fall inside the load window that follows an arming prefix. Command bytes must arrive with a minimum and a maximum spacing, counted in microsecond ticks. A pair that breaks a sequence, or a gap that is too long or too short, drops the partial sequence.

Top module: `wrguard`

## Requirements
- R1: After reset the lock flag `protOn` is 0 and a write that is not 5555/AA is permitted.
- R2: While unlocked and outside any sequence, a write other than address 5555 with data AA (hex) raises `wrPermit` in the same cycle as `wrStb`. `wrPermit` is never high without `wrStb`.
- R3: A write accepted as a step of a command sequence never raises `wrPermit`. In particular, a 5555/AA write while unlocked is never permitted.
- R4: The writes 5555/AA, 2AAA/55 and 5555/A0 (hex, low 15 address bits) set `protOn` to 1 in the cycle after the third write. `protOn` changes only in the cycle after a write.
- R5: After the arming prefix, each following write is permitted as long as it comes no more than MAX_GAP (30) ticks after the previous write. `protOn` stays 1 throughout.
- R6: While locked and outside a load window, a write that is not a sequence step is refused (`wrPermit` low).
- R7: The six writes 5555/AA, 2AAA/55, 5555/80, 5555/AA, 2AAA/55, 5555/20 clear `protOn` in the cycle after the sixth write.
- R8: Only address bits 14..0 are compared against 5555 and 2AAA. Bits 16..15 have no effect on matching.
- R9: A write that does not match the expected next step aborts the partial sequence. That write is then judged afresh: 5555/AA starts a new sequence; any other pair is a plain write, permitted only while unlocked.
- R10: When more than MAX_GAP ticks (that is, MAX_GAP+1 ticks) pass with no write, a partial sequence or a load window returns to idle. A step that comes exactly MAX_GAP ticks after the previous one is still accepted.
- R11: A step that comes fewer than MIN_GAP (1) ticks after the previous command byte aborts the sequence and is judged afresh.
- R12: When a load window times out, the lock stays on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | One-cycle pulse per latched bus write |
| wrAddr | input | 17 | Latched write address |
| wrData | input | 8 | Latched write data |
| usTick | input | 1 | One-cycle pulse every microsecond |
| wrPermit | output | 1 | Write may go to the page engine (same cycle as wrStb) |
| protOn | output | 1 | Software lock is enabled |

## Verification
The assertions assume that `wrStb` is a single-cycle pulse, that address and data are valid whenever it is high, and that `wrStb` and `usTick` stay low during reset. They also assume that `protOn` can only be cleared from a state reached while it was set. The bench drives each write for exactly one cycle at a falling edge. It never puts a tick and a write in the same cycle, so the tick count between writes is exact. Random gaps lie mostly under the limit and sometimes straddle MAX_GAP, and random high address bits exercise the partial compare.

// File: rtl/wrguard_pkg.sv
`timescale 1ns/1ps
package wrguard_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM1,
    ST_ARM2,
    ST_REL3,
    ST_REL4,
    ST_REL5,
    ST_LOAD
  } seqState_t;

  // Strobes from the control to the gap counter.
  typedef struct packed {
    logic clrGap;
    logic runGap;
  } gapCtl_t;

  // Address/data pair matches reported by the datapath.
  typedef struct packed {
    logic pairAA;   // first-address / first code
    logic pair55;   // second-address / second code
    logic pairLock; // first-address / arm code
    logic pairRel;  // first-address / release-intro code
    logic pairFin;  // first-address / release-final code
  } pairHit_t;

endpackage

// File: rtl/wrguard_dp.sv
`timescale 1ns/1ps
module wrguard_dp
  import wrguard_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CMP_W    = 15,
  parameter int MIN_GAP  = 1,
  parameter int MAX_GAP  = 30,
  parameter logic [CMP_W-1:0]  ADDR_ONE = 15'h5555,
  parameter logic [CMP_W-1:0]  ADDR_TWO = 15'h2AAA,
  parameter logic [DATA_W-1:0] CODE_AA  = 8'hAA,
  parameter logic [DATA_W-1:0] CODE_55  = 8'h55,
  parameter logic [DATA_W-1:0] CODE_ARM = 8'hA0,
  parameter logic [DATA_W-1:0] CODE_REL = 8'h80,
  parameter logic [DATA_W-1:0] CODE_FIN = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              usTick,
  input  gapCtl_t           gapCtl,
  output pairHit_t          hits,
  output logic              gapShort,
  output logic              gapExpire
);

  localparam int GAP_W = $clog2(MAX_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MAX_GAP);
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(MIN_GAP);

  logic [CMP_W-1:0] addrLo;
  logic             atOne;
  logic             atTwo;
  logic [GAP_W-1:0] gapCnt;

  assign addrLo = wrAddr[CMP_W-1:0];
  assign atOne  = (addrLo == ADDR_ONE);
  assign atTwo  = (addrLo == ADDR_TWO);

  always_comb begin
    hits.pairAA   = atOne && (wrData == CODE_AA);
    hits.pair55   = atTwo && (wrData == CODE_55);
    hits.pairLock = atOne && (wrData == CODE_ARM);
    hits.pairRel  = atOne && (wrData == CODE_REL);
    hits.pairFin  = atOne && (wrData == CODE_FIN);
  end

  // Ticks since the last write; holds at the limit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (gapCtl.clrGap) begin
      gapCnt <= '0;
    end else if (gapCtl.runGap && usTick && (gapCnt != GAP_LIM)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  assign gapShort  = (gapCnt < GAP_MIN);
  assign gapExpire = gapCtl.runGap && usTick && (gapCnt == GAP_LIM);

endmodule

// File: rtl/wrguard_ctl.sv
`timescale 1ns/1ps
module wrguard_ctl
  import wrguard_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrStb,
  input  pairHit_t hits,
  input  logic     gapShort,
  input  logic     gapExpire,
  output gapCtl_t  gapCtl,
  output logic     wrPermit,
  output logic     protOn
);

  seqState_t state;
  seqState_t stateNxt;
  logic      protNxt;
  logic      advanced;
  logic      stepOk;

  assign stepOk = !gapShort;

  always_comb begin
    stateNxt = state;
    protNxt  = protOn;
    wrPermit = 1'b0;
    advanced = 1'b0;
    if (wrStb) begin
      unique case (state)
        ST_LOAD: begin
          wrPermit = 1'b1;
          advanced = 1'b1;
        end
        ST_ARM1: begin
          if (stepOk && hits.pair55) begin
            stateNxt = ST_ARM2;
            advanced = 1'b1;
          end
        end
        ST_ARM2: begin
          if (stepOk && hits.pairLock) begin
            stateNxt = ST_LOAD;
            protNxt  = 1'b1;
            advanced = 1'b1;
          end else if (stepOk && hits.pairRel) begin
            stateNxt = ST_REL3;
            advanced = 1'b1;
          end
        end
        ST_REL3: begin
          if (stepOk && hits.pairAA) begin
            stateNxt = ST_REL4;
            advanced = 1'b1;
          end
        end
        ST_REL4: begin
          if (stepOk && hits.pair55) begin
            stateNxt = ST_REL5;
            advanced = 1'b1;
          end
        end
        ST_REL5: begin
          if (stepOk && hits.pairFin) begin
            stateNxt = ST_IDLE;
            protNxt  = 1'b0;
            advanced = 1'b1;
          end
        end
        default: ;
      endcase
      if (!advanced) begin
        if (hits.pairAA) begin
          stateNxt = ST_ARM1;
        end else begin
          stateNxt = ST_IDLE;
          wrPermit = !protOn;
        end
      end
    end else if (gapExpire) begin
      stateNxt = ST_IDLE;
    end
  end

  always_comb begin
    gapCtl.clrGap = wrStb;
    gapCtl.runGap = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      protOn <= 1'b0;
    end else begin
      state  <= stateNxt;
      protOn <= protNxt;
    end
  end

endmodule

// File: rtl/wrguard.sv
`timescale 1ns/1ps
module wrguard
  import wrguard_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CMP_W   = 15,
  parameter int MIN_GAP = 1,
  parameter int MAX_GAP = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              usTick,
  output logic              wrPermit,
  output logic              protOn
);

  gapCtl_t  gapCtl;
  pairHit_t hits;
  logic     gapShort;
  logic     gapExpire;

  wrguard_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CMP_W  (CMP_W),
    .MIN_GAP(MIN_GAP),
    .MAX_GAP(MAX_GAP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .usTick   (usTick),
    .gapCtl   (gapCtl),
    .hits     (hits),
    .gapShort (gapShort),
    .gapExpire(gapExpire)
  );

  wrguard_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .wrStb    (wrStb),
    .hits     (hits),
    .gapShort (gapShort),
    .gapExpire(gapExpire),
    .gapCtl   (gapCtl),
    .wrPermit (wrPermit),
    .protOn   (protOn)
  );

endmodule

// File: rtl/wrguard_chk.sv
`timescale 1ns/1ps
module wrguard_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStb,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              wrPermit,
  input logic              protOn
);

  logic isOneAA;
  logic isArm;
  logic isFin;

  assign isOneAA = (wrAddr[14:0] == 15'h5555) && (wrData == 8'hAA);
  assign isArm   = (wrAddr[14:0] == 15'h5555) && (wrData == 8'hA0);
  assign isFin   = (wrAddr[14:0] == 15'h5555) && (wrData == 8'h20);

  assert_permit_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrPermit |-> wrStb);

  assert_cmd_hidden_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !protOn && isOneAA) |-> !wrPermit);

  assert_lock_moves_on_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(protOn) |-> $past(wrStb));

  assert_lock_set_by_arm_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protOn) |-> $past(isArm));

  assert_lock_clear_by_fin_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protOn) |-> $past(isFin));

endmodule

bind wrguard wrguard_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrStb   (wrStb),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .wrPermit(wrPermit),
  .protOn  (protOn)
);

// File: tb/sim_wrguard.sv
`timescale 1ns/1ps
module sim_wrguard;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrStb;
  logic [16:0] wrAddr;
  logic [7:0]  wrData;
  logic        usTick;
  logic        wrPermit;
  logic        protOn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model: 0 idle, 1..2 arming, 3..5 release, 6 load window
  int mState = 0;
  int mGap   = 0;
  bit mProt  = 1'b0;

  always #4 clk = ~clk;

  wrguard u0 (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr),
    .wrData(wrData), .usTick(usTick), .wrPermit(wrPermit), .protOn(protOn)
  );

  function automatic bit mWrite(input logic [16:0] a, input logic [7:0] d);
    bit one, two, adv, pm;
    one = (a[14:0] == 15'h5555);
    two = (a[14:0] == 15'h2AAA);
    adv = 1'b0;
    pm  = 1'b0;
    if (mState == 6) begin
      pm = 1'b1; adv = 1'b1;
    end else if (mState >= 1 && mState <= 5 && mGap >= 1) begin
      case (mState)
        1: if (two && d == 8'h55) begin mState = 2; adv = 1'b1; end
        2: if (one && d == 8'hA0) begin mState = 6; mProt = 1'b1; adv = 1'b1; end
           else if (one && d == 8'h80) begin mState = 3; adv = 1'b1; end
        3: if (one && d == 8'hAA) begin mState = 4; adv = 1'b1; end
        4: if (two && d == 8'h55) begin mState = 5; adv = 1'b1; end
        5: if (one && d == 8'h20) begin mState = 0; mProt = 1'b0; adv = 1'b1; end
        default: ;
      endcase
    end
    if (!adv) begin
      if (one && d == 8'hAA) mState = 1;
      else begin mState = 0; pm = !mProt; end
    end
    mGap = 0;
    return pm;
  endfunction

  function automatic void mTick();
    if (mState != 0) begin
      if (mGap == 30) mState = 0;
      else mGap = mGap + 1;
    end
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d, input string tag);
    bit ep;
    ep = mWrite(a, d);
    @(negedge clk);
    wrStb = 1'b1; wrAddr = a; wrData = d;
    #1;
    chk({tag, " permit"}, wrPermit, ep);
    @(negedge clk);
    wrStb = 1'b0;
    chk({tag, " lock"}, protOn, mProt);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); usTick = 1'b1; mTick();
      @(negedge clk); usTick = 1'b0;
    end
  endtask

  task automatic armSeq(input logic [1:0] hi, input string tag);
    wr({hi, 15'h5555}, 8'hAA, tag); ticks(2);
    wr({hi, 15'h2AAA}, 8'h55, tag); ticks(2);
    wr({hi, 15'h5555}, 8'hA0, tag); ticks(2);
  endtask

  task automatic relSeq(input string tag);
    wr(17'h05555, 8'hAA, tag); ticks(1);
    wr(17'h02AAA, 8'h55, tag); ticks(1);
    wr(17'h05555, 8'h80, tag); ticks(1);
    wr(17'h05555, 8'hAA, tag); ticks(1);
    wr(17'h02AAA, 8'h55, tag); ticks(1);
    wr(17'h05555, 8'h20, tag); ticks(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; wrStb = 1'b0; wrAddr = '0; wrData = '0; usTick = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset lock", protOn, 1'b0);
    wr(17'h01234, 8'h3C, "R1");
    wr(17'h00010, 8'hAA, "R2");

    // arm, load window, timeout, refusal
    armSeq(2'b00, "R3");
    chk("R4 lock set", protOn, 1'b1);
    wr(17'h00100, 8'h11, "R5"); ticks(30);
    wr(17'h00101, 8'h22, "R5"); ticks(5);
    wr(17'h00102, 8'h33, "R5");
    ticks(31);
    wr(17'h00103, 8'h44, "R6");
    chk("R12 lock kept", protOn, 1'b1);

    // high address bits ignored
    armSeq(2'b11, "R8");
    wr(17'h18000, 8'h99, "R8");
    ticks(31);

    relSeq("R7");
    chk("R7 lock cleared", protOn, 1'b0);
    wr(17'h00200, 8'h5A, "R2");

    // mismatch abort
    wr(17'h05555, 8'hAA, "R9"); ticks(2);
    wr(17'h01234, 8'h77, "R9");
    wr(17'h05555, 8'hAA, "R9"); ticks(2);
    wr(17'h05555, 8'hAA, "R9"); ticks(2);
    wr(17'h02AAA, 8'h55, "R9"); ticks(2);
    wr(17'h00300, 8'h01, "R9");

    // too-short gap
    wr(17'h05555, 8'hAA, "R11");
    wr(17'h02AAA, 8'h55, "R11");

    // too-long gap, then exact limit
    wr(17'h05555, 8'hAA, "R10"); ticks(31);
    wr(17'h02AAA, 8'h55, "R10");
    wr(17'h05555, 8'hAA, "R10"); ticks(30);
    wr(17'h02AAA, 8'h55, "R10"); ticks(30);
    wr(17'h05555, 8'hA0, "R10");
    chk("R10 lock at limit", protOn, 1'b1);
    ticks(31);
    relSeq("R7");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k, g;
      logic [16:0] a;
      logic [7:0]  d;
      k = int'($urandom % 8);
      a = {2'($urandom), 15'h5555};
      case (k)
        0: d = 8'hAA;
        1: begin a[14:0] = 15'h2AAA; d = 8'h55; end
        2: d = 8'hA0;
        3: d = 8'h80;
        4: d = 8'h20;
        default: begin a = 17'($urandom); d = 8'($urandom); end
      endcase
      wr(a, d, "R9 rand");
      g = int'($urandom % 10);
      if (g == 9) g = 28 + int'($urandom % 5);
      ticks(g);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule